// File: doc/BRIEF.md
# Signed Sample to Compact Float Converter

This block turns a stream of 16-bit signed two's-complement samples into 23-bit floating-point words. Each word packs a 6-bit exponent in its top bits, then a sign bit, then 16 stored mantissa bits. The full mantissa is 17 bits long and kept normalized, so its leading bit is always 1 for a nonzero value and is left out of the packed word. The encoded value is (-1)^S x M x 2^(E-33), where M is the 17-bit mantissa with the hidden bit restored. An exponent of 0 encodes zero.

The datapath has three register stages. The first takes the sign and a ones' complement magnitude. The second counts leading zeros. The third normalizes with a logarithmic shifter and forms the exponent. The magnitude is the input XOR-ed with its own sign bit, with no +1 correction. Negative inputs therefore come out one step smaller in magnitude than their true value, and -1 maps to zero.

Both sides use valid/ready handshakes. A sample moves on an edge where in_valid and in_ready are both high. A result leaves on an edge where out_valid and out_ready are both high. The whole pipeline advances together whenever the output register is empty or is being taken. When the output is full and out_ready is low, every stage holds and in_ready drops in the same cycle. A producer must keep in_data steady while in_valid is high and in_ready is low.

Top module: `int_to_minifloat`

## Requirements
- R1: For a nonzero magnitude with L leading zeros in 16 bits, out_word[22:17] equals 32 - L, which lies in the range 17..31.
- R2: out_word[16] equals bit 15 of the accepted sample whenever the magnitude is nonzero.
- R3: The magnitude is the sample XOR-ed bitwise with its bit 15, with no increment. For example, 16'hFFFE gives magnitude 1 and the word 23'h230000.
- R4: The 17-bit mantissa is the magnitude shifted left by L+1, so its bit 16 is 1. out_word[15:0] carries the lower 16 bits of that mantissa, and the hidden bit is not stored.
- R5: A zero magnitude (inputs 16'h0000 and 16'hFFFF) gives the all-zero word, with the sign bit also cleared.
- R6: While out_ready stays high, a result appears on out_valid exactly 3 cycles after the sample is accepted, and one sample is accepted every clock.
- R7: While out_valid is high and out_ready is low, out_word and out_valid hold steady. in_ready equals (not out_valid) or out_ready.
- R8: Results leave in the order their samples were accepted, each exactly once, with bubbles in the input stream passed through and no result lost or duplicated.
- R9: While rst_n is low, and after it is released until the first sample arrives, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample on in_data is valid |
| in_ready | output | 1 | Block takes the sample on this edge |
| in_data | input | 16 | Signed two's-complement sample |
| out_valid | output | 1 | out_word holds a result |
| out_ready | input | 1 | Consumer takes out_word on this edge |
| out_word | output | 23 | Packed {exponent, sign, stored mantissa} |

## Verification
A wrong leading-zero count shows up at the ports as an exponent and a mantissa that are both off. It surfaces three cycles after the sample enters, on the first result whose magnitude hits the faulty bit position. The full sweep of all 65536 codes therefore catches it at once. A stall or valid-tracking error shows as a changed word during back-pressure, a missing or duplicated result, or a result delivered out of order. These faults become visible on the first stalled cycle or at the drain that follows. Ones' complement corner codes (0, -1, -2, most negative) are checked directly against hand-computed words.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  // Default geometry of the converter
  localparam int unsigned SAMPLE_W  = 16;
  localparam int unsigned EXPN_W    = 6;
  // Exponent assigned to a magnitude with zero leading zeros
  localparam int unsigned EXPN_BASE = 2 * SAMPLE_W;
endpackage

// File: rtl/i2f_lead_zero.sv
module i2f_lead_zero #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count,
  output logic          all_zero
);
  logic hit;

  // Scan from the top bit; count positions until the first one
  always_comb begin
    count = '0;
    hit   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (vec[i]) hit = 1'b1;
        else        count = count + CW'(1);
      end
    end
  end

  assign all_zero = ~|vec;
endmodule

// File: rtl/i2f_norm_shift.sv
module i2f_norm_shift #(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = 5,
  localparam int unsigned OW = W + 1
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amount,
  output logic [OW-1:0] dout
);
  logic [OW-1:0] level [SW+1];

  assign level[0] = OW'(din);

  // One conditional shift per bit of the shift amount
  for (genvar k = 0; k < SW; k++) begin : g_level
    assign level[k+1] = amount[k] ? (level[k] << (1 << k)) : level[k];
  end

  assign dout = level[SW];
endmodule

// File: rtl/int_to_minifloat.sv
module int_to_minifloat #(
  parameter int unsigned IN_W     = i2f_pkg::SAMPLE_W,
  parameter int unsigned EXP_W    = i2f_pkg::EXPN_W,
  parameter int unsigned EXP_BASE = i2f_pkg::EXPN_BASE,
  localparam int unsigned OUT_W   = EXP_W + 1 + IN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_word
);
  localparam int unsigned CW      = $clog2(IN_W + 1);
  localparam int unsigned FULL_W  = IN_W + 1;
  localparam int unsigned EXP_MIN = EXP_BASE - IN_W + 1;
  localparam int unsigned EXP_MAX = EXP_BASE - 1;
  localparam logic [EXP_W-1:0] BASE_V = EXP_W'(EXP_BASE);

  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // Stage 1: sign and ones' complement magnitude
  logic            v1, sg1;
  logic [IN_W-1:0] mag1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      sg1  <= 1'b0;
      mag1 <= '0;
    end else if (advance) begin
      v1   <= in_valid;
      sg1  <= in_data[IN_W-1];
      mag1 <= in_data ^ {IN_W{in_data[IN_W-1]}};
    end
  end

  // Stage 2: leading-zero count and zero detect
  logic [CW-1:0]   lz1;
  logic            z1;

  i2f_lead_zero #(.W(IN_W)) u_lzc (
    .vec      (mag1),
    .count    (lz1),
    .all_zero (z1)
  );

  logic            v2, sg2, z2;
  logic [IN_W-1:0] mag2;
  logic [CW-1:0]   lz2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      sg2  <= 1'b0;
      z2   <= 1'b1;
      mag2 <= '0;
      lz2  <= '0;
    end else if (advance) begin
      v2   <= v1;
      sg2  <= sg1;
      z2   <= z1;
      mag2 <= mag1;
      lz2  <= lz1;
    end
  end

  // Stage 3: normalize and form the exponent
  logic [FULL_W-1:0] full_man;
  logic [CW-1:0]     shamt;
  logic [EXP_W-1:0]  expn;

  assign shamt = lz2 + CW'(1);
  assign expn  = BASE_V - EXP_W'(lz2);

  i2f_norm_shift #(.W(IN_W), .SW(CW)) u_shift (
    .din    (mag2),
    .amount (shamt),
    .dout   (full_man)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (advance) begin
      out_valid <= v2;
      out_word  <= z2 ? '0 : {expn, sg2, full_man[IN_W-1:0]};
    end
  end

  // Checks beside the logic they guard
  AST_MAG_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> !mag1[IN_W-1]);                                             // R3
  AST_LZC_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !z2) |-> ((mag2 >> (IN_W - 1 - int'(lz2))) == IN_W'(1)));   // R1
  AST_HIDDEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !z2) |-> full_man[IN_W]);                                    // R4
  AST_EXP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[OUT_W-1 -: EXP_W] != '0) |->
      (int'(out_word[OUT_W-1 -: EXP_W]) >= EXP_MIN &&
       int'(out_word[OUT_W-1 -: EXP_W]) <= EXP_MAX));                  // R1
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[OUT_W-1 -: EXP_W] == '0) |->
      (out_word[IN_W:0] == '0));                                        // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));    // R7
endmodule

// File: tb/int_to_minifloat_test.sv
module int_to_minifloat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [22:0] out_word;

  always #4 clk = ~clk;  // 125 MHz

  int_to_minifloat uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Hand-computed vectors: {sample, expected word}
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {16'h0000, 23'h000000},  // R5 zero
    {16'hFFFF, 23'h000000},  // R5 minus one -> zero magnitude
    {16'h0001, 23'h220000},  // R1 smallest exponent 17
    {16'hFFFE, 23'h230000},  // R3 no +1 correction
    {16'h7FFF, 23'h3EFFFC},  // R1 R4 largest positive
    {16'h8000, 23'h3FFFFC},  // R2 R3 most negative
    {16'h4000, 23'h3E0000},
    {16'h0002, 23'h240000},
    {16'h0003, 23'h248000},  // R4 stored bits below hidden one
    {16'h1234, 23'h3A2340},
    {16'hEDCB, 23'h3B2340},  // R2 sign set
    {16'h00FF, 23'h30FE00},
    {16'hC000, 23'h3DFFF8},
    {16'h0100, 23'h320000}
  };

  // Reference built from R1..R5 alone
  function automatic logic [22:0] ref_word(input logic [15:0] x);
    logic        s;
    logic [15:0] m;
    int          e;
    s = x[15];
    m = s ? ~x : x;
    if (m == 16'h0) return 23'h0;
    e = 32;
    while (!m[15]) begin
      m = m << 1;
      e--;
    end
    return {6'(e), s, m[14:0], 1'b0};
  endfunction

  // Scoreboard ring
  logic [22:0] rq_w [16];
  int          rq_c [16];
  logic [3:0]  wr = '0, rd = '0;
  int          inflight = 0;
  int          cyc = 0;
  bit          lat_on = 1'b0;
  string       phase = "R1 R2 R3 R4 R5";

  task automatic fail_line(input string req, input logic [31:0] act, input logic [31:0] exp);
    fails++;
    $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  // One cycle: drive, then account for the coming edge
  task automatic step(input logic v, input logic [15:0] d, input logic [22:0] expw,
                      input logic rdy, output logic acc);
    in_valid  = v;
    in_data   = d;
    out_ready = rdy;
    #1;
    acc = v && in_ready;
    if (out_valid && out_ready) begin
      checks++;
      if (inflight == 0) fail_line("R8 unexpected output", 32'(out_word), 32'h0);
      else begin
        if (out_word !== rq_w[rd]) fail_line(phase, 32'(out_word), 32'(rq_w[rd]));
        if (lat_on) begin
          checks++;
          if (cyc - rq_c[rd] != 3) fail_line("R6 latency", 32'(cyc - rq_c[rd]), 32'd3);
        end
        rd = rd + 4'd1;
        inflight--;
      end
    end
    if (acc) begin
      rq_w[wr] = expw;
      rq_c[wr] = cyc;
      wr = wr + 4'd1;
      inflight++;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) fail_line(req, 32'(act), 32'(exp));
  endtask

  initial begin
    logic acc;
    logic [22:0] held;
    int got;
    // R9 reset state
    repeat (3) @(negedge clk);
    check_bit("R9 out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R9 out_valid after reset", out_valid, 1'b0);
    check_bit("R9 in_ready after reset", in_ready, 1'b1);

    // Table walk, streaming back to back (R1..R6)
    lat_on = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][38:23], VEC[i][22:0], 1'b1, acc);
      if (!acc) fail_line("R6 not accepted", 32'd0, 32'd1);
    end
    // Bubbled pattern (R8)
    phase = "R8 bubbles";
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 16'(i * 16'h0911), ref_word(16'(i * 16'h0911)), 1'b1, acc);
      step(1'b0, 16'hDEAD, 23'h0, 1'b1, acc);
    end
    repeat (5) step(1'b0, 16'h0, 23'h0, 1'b1, acc);

    // Back-pressure (R7)
    lat_on = 1'b0;
    phase = "R7 R8 stall drain";
    got = 0;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 16'(16'h0040 + got), ref_word(16'(16'h0040 + got)), 1'b0, acc);
      if (acc) got++;
    end
    checks++;
    if (got != 3) fail_line("R7 accepted while stalled", 32'(got), 32'd3);
    check_bit("R7 in_ready low when full", in_ready, 1'b0);
    check_bit("R7 out_valid held", out_valid, 1'b1);
    held = out_word;
    step(1'b0, 16'h0, 23'h0, 1'b0, acc);
    step(1'b0, 16'h0, 23'h0, 1'b0, acc);
    checks++;
    if (out_word !== held) fail_line("R7 word changed in stall", 32'(out_word), 32'(held));
    repeat (6) step(1'b0, 16'h0, 23'h0, 1'b1, acc);

    // Full sweep against the reference (R1..R6)
    lat_on = 1'b1;
    phase = "R1 R2 R3 R4 R5 sweep";
    for (int i = 0; i < 65536; i++) begin
      step(1'b1, 16'(i), ref_word(16'(i)), 1'b1, acc);
      if (!acc) fail_line("R6 sweep not accepted", 32'd0, 32'd1);
    end
    repeat (6) step(1'b0, 16'h0, 23'h0, 1'b1, acc);
    checks++;
    if (inflight != 0) fail_line("R8 results missing", 32'(inflight), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule